// File: doc/BRIEF.md
# Quad Double-Buffered DAC Code Register Interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host writes codes over one shared 8-bit parallel bus. A two-bit channel select picks the channel, and an active-low write strobe gates the transfer. Each channel keeps its code in two ranks of storage. The first rank is a staging register that the host writes. The second rank is an output register, and its contents alone form the code sent to the converter for that channel.

An active-low load strobe moves every staging register into its output register on the same clock edge. The host can therefore prepare all four channels one at a time and then change all four outputs together. Each output code D stands for the fraction D/256 of that channel's reference. The analog side lies outside this block.

The strobes are sampled in the system clock domain. While the write strobe is low, the selected staging register follows the bus on every clock. On the first clock where the strobe is seen high again, the register takes the bus one last time and then holds.

Top module: `quad_dac_regif`

## Requirements
- R1: A synchronous active-low reset clears all four staging registers and all four output registers to code 0x00.
- R2: Channel select value 0 addresses channel A, 1 addresses B, 2 addresses C and 3 addresses D. A write changes only the addressed staging register.
- R3: On each clock edge where the write strobe is sampled low, the addressed staging register takes the bus value.
- R4: On the first clock edge where the write strobe is sampled high after being low, the staging register addressed at that edge takes the bus value once more. After that edge it holds.
- R5: A staging register holds its value on every edge where it is neither written nor captured.
- R6: Output codes do not change on any edge where the load strobe is sampled high, whatever happens on the write side.
- R7: On each edge where the load strobe is sampled low, all four output registers take the values their staging registers held before that edge.
- R8: When the write and load strobes are both low on the same edge, the output receives the staging value from before the write. The new value reaches the output on the next edge if the load strobe is still low.
- R9: The output bus carries channel k at bits [8k+7:8k], with channel A in the lowest byte. Each field is an unsigned binary code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Shared code bus |
| chan_sel | input | 2 | Channel select (0=A .. 3=D) |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load strobe for all channels |
| dac_codes | output | 32 | Four output codes, channel A in the lowest byte |

## Verification
The bench targets four cases.

- **Capture edge when the strobe rises.** The bench changes the channel select on that very cycle. A design that captured at the old address, or skipped the capture, would leave a stale value in the wrong channel.
- **Write and load together.** The bench asserts both strobes at once. A design that forwarded the bus straight to the output would show the new code one cycle early.
- **Outputs must not move while the load strobe is high.** The bench watches them during writes. Single-buffered logic would make them follow each write.
- **Reset in the middle of a run, followed by a load.** The bench checks that the staging rank was cleared as well as the output rank. If it were not, old codes would reappear after the load.

// File: rtl/quad_dac_pkg.sv
// Package: shared sizing constants for the quad DAC register interface.
// Assumes: one code width shared by every channel.
package quad_dac_pkg;
    localparam int unsigned DEF_CODE_W = 8;
    localparam int unsigned DEF_NUM_CH = 4;
endpackage

// File: rtl/dac_wr_ctrl.sv
// Module: dac_wr_ctrl
// Turns the sampled active-low write strobe and the channel select into
// one-hot per-channel write enables. An enable is raised on every cycle the
// strobe is low and on the first cycle it is seen high again (capture edge).
// Assumes: wr_n and chan_sel are already synchronous to clk.
module dac_wr_ctrl #(
    parameter int unsigned NUM_CH = quad_dac_pkg::DEF_NUM_CH,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [SEL_W-1:0]  chan_sel,
    output logic [NUM_CH-1:0] wr_en
);

    logic wr_n_prev;
    logic write_act;

    // Remember last sampled strobe level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_prev <= 1'b1;
        else        wr_n_prev <= wr_n;
    end

    // Active while strobe is low, or on the first cycle after it rises.
    always_comb write_act = !wr_n || !wr_n_prev;

    // Decode the channel select into one enable per channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
        always_comb wr_en[k] = write_act && (chan_sel == SEL_W'(k));
    end

    // R2: never more than one channel is written at once.
    p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R4: the cycle after a low strobe always produces a capture enable.
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_en != '0));

endmodule

// File: rtl/dac_chan.sv
// Module: dac_chan
// One channel's two storage ranks: a staging register written from the bus
// and an output register loaded from the staging register.
// Assumes: wr_en and ld_en are single-cycle qualified enables in clk domain.
module dac_chan #(
    parameter int unsigned CODE_W = quad_dac_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] bus_data,
    output logic [CODE_W-1:0] dac_code
);

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] out_q;

    // Staging rank: take the bus while enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (wr_en) stage_q <= bus_data;
    end

    // Output rank: copy the staging value while load is active.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= '0;
        else if (ld_en) out_q <= stage_q;
    end

    // Drive the channel code from the output rank only.
    always_comb dac_code = out_q;

    // R3: an enabled write lands the bus value in the staging rank.
    p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (stage_q == $past(bus_data)));

    // R5: without an enable the staging rank keeps its value.
    p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage_q));

    // R6: the output stays put while load is inactive.
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(dac_code));

    // R7/R8: a load takes the staging value from before the edge.
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (dac_code == $past(stage_q)));

endmodule

// File: rtl/quad_dac_regif.sv
// Module: quad_dac_regif
// Double-buffered code register front end for a multi-channel DAC. A shared
// bus writes staging registers chosen by chan_sel under wr_n. ld_n moves all
// staging registers to the outputs on the same edge.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module quad_dac_regif #(
    parameter int unsigned CODE_W = quad_dac_pkg::DEF_CODE_W,
    parameter int unsigned NUM_CH = quad_dac_pkg::DEF_NUM_CH,
    localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        bus_data,
    input  logic [SEL_W-1:0]         chan_sel,
    input  logic                     wr_n,
    input  logic                     ld_n,
    output logic [NUM_CH*CODE_W-1:0] dac_codes
);

    logic [NUM_CH-1:0] wr_en;
    logic              ld_en;

    // Load strobe is active low and common to every channel.
    always_comb ld_en = !ld_n;

    dac_wr_ctrl #(.NUM_CH(NUM_CH)) u_wr_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .chan_sel (chan_sel),
        .wr_en    (wr_en)
    );

    // One channel instance per output code field.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        dac_chan #(.CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[k]),
            .ld_en    (ld_en),
            .bus_data (bus_data),
            .dac_code (dac_codes[k*CODE_W +: CODE_W])
        );
    end

    // R1: one cycle after reset every code reads zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dac_codes == '0));

endmodule

// File: tb/quad_dac_regif_tb.sv
// Bench: walks a vector table, then directed reset checks.
module quad_dac_regif_tb;

    localparam int unsigned NV = 20;
    // Fields: {wr_n, ld_n, sel[1:0], data[7:0], expected {D,C,B,A}}
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 8'h11, 32'h00000000}, // R3 A follows bus
        {1'b1, 1'b1, 2'd0, 8'h22, 32'h00000000}, // R4 capture on rise
        {1'b1, 1'b1, 2'd0, 8'h33, 32'h00000000}, // R5 hold
        {1'b0, 1'b1, 2'd1, 8'h44, 32'h00000000}, // R2 B
        {1'b1, 1'b1, 2'd1, 8'h44, 32'h00000000},
        {1'b0, 1'b1, 2'd2, 8'h55, 32'h00000000}, // R2 C
        {1'b1, 1'b1, 2'd2, 8'h55, 32'h00000000},
        {1'b0, 1'b1, 2'd3, 8'h66, 32'h00000000}, // R2 D
        {1'b1, 1'b1, 2'd3, 8'h66, 32'h00000000}, // R6 no change yet
        {1'b1, 1'b0, 2'd0, 8'h00, 32'h66554422}, // R7 load all
        {1'b1, 1'b1, 2'd0, 8'h99, 32'h66554422}, // R6 hold
        {1'b0, 1'b1, 2'd1, 8'hAB, 32'h66554422}, // R6 write no effect
        {1'b1, 1'b1, 2'd1, 8'hAB, 32'h66554422},
        {1'b0, 1'b0, 2'd0, 8'h0F, 32'h6655AB22}, // R8 old staging value
        {1'b1, 1'b0, 2'd0, 8'h0F, 32'h6655AB0F}, // R8 new one next edge
        {1'b1, 1'b1, 2'd3, 8'hFF, 32'h6655AB0F},
        {1'b0, 1'b1, 2'd3, 8'hFF, 32'h6655AB0F},
        {1'b1, 1'b1, 2'd2, 8'h01, 32'h6655AB0F}, // R4 capture at new sel
        {1'b1, 1'b0, 2'd0, 8'h00, 32'hFF01AB0F}, // R7 load
        {1'b1, 1'b1, 2'd0, 8'h00, 32'hFF01AB0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [1:0]  chan_sel = '0;
    logic        wr_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [31:0] dac_codes;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quad_dac_regif u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .chan_sel  (chan_sel),
        .wr_n      (wr_n),
        .ld_n      (ld_n),
        .dac_codes (dac_codes)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic w, input logic l, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_n = w; ld_n = l; chan_sel = s; bus_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b1, 1'b1, 2'd0, 8'h00);
        check("R1 reset state", dac_codes, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][43], VEC[i][42], VEC[i][41:40], VEC[i][39:32]);
            check($sformatf("R2..R8 vector %0d", i), dac_codes, VEC[i][31:0]);
        end
        // R9: channel B field sits in bits [15:8], channel D in [31:24].
        check("R9 field B", {24'h0, dac_codes[15:8]}, 32'hAB);
        check("R9 field D", {24'h0, dac_codes[31:24]}, 32'hFF);
        // R1: reset mid-run clears outputs.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 mid-run reset", dac_codes, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R1: staging registers were cleared too, so a load still yields 0.
        step(1'b1, 1'b0, 2'd0, 8'h00);
        check("R1 staging cleared", dac_codes, 32'h0);
        // R2: a write to C alone then load touches only byte 2.
        step(1'b0, 1'b1, 2'd2, 8'hC3);
        step(1'b1, 1'b1, 2'd2, 8'hC3);
        step(1'b1, 1'b0, 2'd0, 8'h00);
        check("R2 only C written", dac_codes, 32'h00C30000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule